// File: doc/BRIEF.md
# DMA Channel Arbitration-Level Mapper

This block keeps a 4-bit arbitration level for each of eight DMA channels. When the bus arbiter reports a granted level, the block returns the single channel that owns that grant. The answer is a one-hot select vector and a hit flag.

Six channels answer to a level equal to their own index, and that level can never change. Two channels (indices 0 and 4) are virtual: software can move each of them to any of the sixteen levels. This lets many requesters share them in turn.

The channel table is registered. A write changes the table at the next rising clock edge. The lookup is combinational from the table, so a grant is answered in the same cycle it is presented.

A channel that is flagged busy is passed over. The lookup then goes on to the next matching channel, so the grant is served by any free channel that holds the level.

Top module: `arb_level_mapper`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), channel n holds level n for n = 0..7. A valid grant of level n with no busy flags therefore selects bit n of ch_sel (bit i corresponds to channel i).
- R2: A write with wr_en high and wr_ch equal to 0 or 4 stores wr_lvl, which may be any value 0..15, into that channel. Lookups use the new level from the cycle after the write edge.
- R3: A write addressed to channel 1, 2, 3, 5, 6 or 7 leaves that channel's level unchanged.
- R4: A channel is selected only when grant_valid is high and grant_lvl equals the channel's current level. A virtual channel that has been moved no longer answers its old level.
- R5: With grant_valid low, ch_sel is all zero and hit is low, whatever the value of grant_lvl.
- R6: When no channel holds the granted level, ch_sel is all zero and hit is low.
- R7: ch_sel has at most one bit set. When several free channels hold the granted level, the lowest-numbered one is selected.
- R8: A channel whose ch_busy bit is high is never selected. The next-lowest free matching channel is chosen instead, and if there is none, hit is low.
- R9: hit is high exactly when ch_sel is nonzero.
- R10: With wr_en low, the values on wr_ch and wr_lvl change no level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Level write strobe |
| wr_ch | input | 3 | Channel index to write |
| wr_lvl | input | 4 | Level value to write |
| grant_valid | input | 1 | Granted level is valid this cycle |
| grant_lvl | input | 4 | Arbitration level that won the bus |
| ch_busy | input | 8 | Per-channel busy flags, bit i = channel i |
| ch_sel | output | 8 | One-hot selected channel, bit i = channel i |
| hit | output | 1 | A channel answers the current grant |

## Verification
A wrong level in the table shows at the ports only when that level, or the channel's correct level, is granted. The bench therefore grants both the old and the new level after every write. Because the lookup is combinational, a corrupted write shows one cycle after its edge. It appears as a missing hit, an extra hit or a wrong select bit.

A broken priority chain or a broken busy mask shows only when several channels are matching or busy together. Ties are therefore built on purpose: the two virtual channels at one level, and a virtual channel placed on a fixed channel's level.

// File: rtl/arb_level_pkg.sv
// Package: shared sizing for the arbitration-level mapper.
// Assumes NUM_CH does not exceed 2**LVL_W, so that every reset level fits.
package arb_level_pkg;
    localparam int NUM_CH    = 8;
    localparam int LVL_W     = 4;
    localparam int CH_IDX_W  = $clog2(NUM_CH);
    // Bit i set marks channel i as software-reassignable.
    localparam logic [NUM_CH-1:0] VIRT_MASK = 8'b0001_0001;
endpackage

// File: rtl/arb_level_table.sv
// Module: arb_level_table
// Holds one arbitration level per channel. Virtual channels (VIRT_MASK)
// get a register that is loaded by the write port. Fixed channels are
// constants equal to their index.
// Assumes a synchronous active-low reset and NUM_CH <= 2**LVL_W.
module arb_level_table #(
    parameter int                NUM_CH    = 8,
    parameter int                LVL_W     = 4,
    parameter logic [NUM_CH-1:0] VIRT_MASK = 8'b0001_0001,
    localparam int               IDX_W     = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_ch,
    input  logic [LVL_W-1:0]              wr_lvl,
    output logic [NUM_CH-1:0][LVL_W-1:0]  levels
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [LVL_W-1:0] HOME = LVL_W'(i);
        if (VIRT_MASK[i]) begin : g_virt
            logic [LVL_W-1:0] lvl_q;
            // Load a new level on an addressed write; return home on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lvl_q <= HOME;
                else if (wr_en && (wr_ch == IDX_W'(i)))
                    lvl_q <= wr_lvl;
            end
            assign levels[i] = lvl_q;
        end else begin : g_fixed
            assign levels[i] = HOME;
        end
    end
endmodule

// File: rtl/arb_level_match.sv
// Module: arb_level_match
// Flags each channel that may answer the grant: the grant is valid, the
// channel's level equals the granted level, and the channel is not busy.
// Purely combinational.
module arb_level_match #(
    parameter int NUM_CH = 8,
    parameter int LVL_W  = 4
) (
    input  logic                          grant_valid,
    input  logic [LVL_W-1:0]              grant_lvl,
    input  logic [NUM_CH-1:0][LVL_W-1:0]  levels,
    input  logic [NUM_CH-1:0]             ch_busy,
    output logic [NUM_CH-1:0]             eligible
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
        assign eligible[i] = grant_valid && (levels[i] == grant_lvl) && !ch_busy[i];
    end
endmodule

// File: rtl/arb_level_pick.sv
// Module: arb_level_pick
// Reduces the eligible vector to one-hot, keeping the lowest-numbered
// set bit. It does this with a ripple chain of "some lower bit is set".
// Purely combinational.
module arb_level_pick #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] eligible,
    output logic [NUM_CH-1:0] sel,
    output logic              any
);
    logic [NUM_CH:0] lower_set;
    assign lower_set[0] = 1'b0;
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
        assign sel[i]         = eligible[i] && !lower_set[i];
        assign lower_set[i+1] = lower_set[i] || eligible[i];
    end
    assign any = lower_set[NUM_CH];
endmodule

// File: rtl/arb_level_mapper.sv
// Module: arb_level_mapper (top)
// Maps a granted arbitration level to the one DMA channel that answers it.
// Level table -> match stage -> lowest-index pick. Writes take effect
// at the next edge; lookups are combinational.
// Assumes a synchronous active-low reset. Grant inputs are stable around
// the sampling point of the consumer.
module arb_level_mapper
    import arb_level_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CH_IDX_W-1:0] wr_ch,
    input  logic [LVL_W-1:0]    wr_lvl,
    input  logic                grant_valid,
    input  logic [LVL_W-1:0]    grant_lvl,
    input  logic [NUM_CH-1:0]   ch_busy,
    output logic [NUM_CH-1:0]   ch_sel,
    output logic                hit
);
    logic [NUM_CH-1:0][LVL_W-1:0] levels;
    logic [NUM_CH-1:0]            eligible;

    arb_level_table #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .VIRT_MASK(VIRT_MASK)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ch  (wr_ch),
        .wr_lvl (wr_lvl),
        .levels (levels)
    );

    arb_level_match #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_match (
        .grant_valid (grant_valid),
        .grant_lvl   (grant_lvl),
        .levels      (levels),
        .ch_busy     (ch_busy),
        .eligible    (eligible)
    );

    arb_level_pick #(.NUM_CH(NUM_CH)) u_pick (
        .eligible (eligible),
        .sel      (ch_sel),
        .any      (hit)
    );

    // R7: never more than one channel driving.
    a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    // R9: hit flag agrees with the select vector.
    a_r9_hit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (ch_sel != '0));

    // R5: no answer without a valid grant.
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (!hit && ch_sel == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4: a selected channel holds exactly the granted level.
        a_r4_level_match: assert property (@(posedge clk) disable iff (!rst_n)
            ch_sel[i] |-> (levels[i] == grant_lvl));
        // R8: a busy channel is never selected.
        a_r8_busy_skip: assert property (@(posedge clk) disable iff (!rst_n)
            ch_sel[i] |-> !ch_busy[i]);
        // R7: no lower-numbered channel was also eligible.
        if (i > 0) begin : g_low
            a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
                ch_sel[i] |-> (eligible[i-1:0] == '0));
        end
    end
endmodule

// File: tb/arb_level_mapper_bench.sv
`timescale 1ns/1ps
module arb_level_mapper_bench;
    typedef struct packed {
        logic       we;
        logic [2:0] ch;
        logic [3:0] lvl;
        logic       gv;
        logic [3:0] gl;
        logic [7:0] busy;
        logic [7:0] sel;
        logic       hit;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd0,  8'h00, 8'h01, 1'b1, 4'd1},  // R1
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd3,  8'h00, 8'h08, 1'b1, 4'd1},  // R1
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd7,  8'h00, 8'h80, 1'b1, 4'd1},  // R1
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd4,  8'h00, 8'h10, 1'b1, 4'd1},  // R1
        '{1'b0, 3'd0, 4'd0,  1'b0, 4'd2,  8'h00, 8'h00, 1'b0, 4'd5},  // R5
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd9,  8'h00, 8'h00, 1'b0, 4'd6},  // R6
        '{1'b1, 3'd0, 4'd12, 1'b1, 4'd12, 8'h00, 8'h01, 1'b1, 4'd2},  // R2
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd0,  8'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{1'b1, 3'd4, 4'd12, 1'b1, 4'd12, 8'h00, 8'h01, 1'b1, 4'd7},  // R7
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd12, 8'h01, 8'h10, 1'b1, 4'd8},  // R8
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd12, 8'h11, 8'h00, 1'b0, 4'd8},  // R8
        '{1'b1, 3'd3, 4'd12, 1'b1, 4'd3,  8'h00, 8'h08, 1'b1, 4'd3},  // R3
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd12, 8'h01, 8'h10, 1'b1, 4'd3},  // R3
        '{1'b0, 3'd4, 4'd5,  1'b1, 4'd12, 8'h00, 8'h01, 1'b1, 4'd10}, // R10
        '{1'b1, 3'd4, 4'd2,  1'b1, 4'd2,  8'h00, 8'h04, 1'b1, 4'd7},  // R7
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd2,  8'h04, 8'h10, 1'b1, 4'd8},  // R8
        '{1'b1, 3'd4, 4'd15, 1'b1, 4'd15, 8'h00, 8'h10, 1'b1, 4'd2},  // R2
        '{1'b1, 3'd0, 4'd0,  1'b1, 4'd0,  8'h00, 8'h01, 1'b1, 4'd2}   // R2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_ch = '0;
    logic [3:0] wr_lvl = '0;
    logic       grant_valid = 1'b0;
    logic [3:0] grant_lvl = '0;
    logic [7:0] ch_busy = '0;
    logic [7:0] ch_sel;
    logic       hit;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    arb_level_mapper u_arb_level_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_lvl(wr_lvl),
        .grant_valid(grant_valid), .grant_lvl(grant_lvl), .ch_busy(ch_busy),
        .ch_sel(ch_sel), .hit(hit)
    );

    task automatic check(input int req, input logic [7:0] exp_sel, input logic exp_hit);
        checks++;
        if (ch_sel !== exp_sel || hit !== exp_hit) begin
            errors++;
            $display("FAIL R%0d: sel=%b hit=%b expected sel=%b hit=%b",
                     req, ch_sel, hit, exp_sel, exp_hit);
        end
        // R7 and R9: at most one select bit, hit mirrors it.
        checks++;
        if ($countones(ch_sel) > 1 || hit !== (ch_sel != 8'h00)) begin
            errors++;
            $display("FAIL R7/R9: sel=%b hit=%b expected one-hot sel with matching hit",
                     ch_sel, hit);
        end
    endtask

    task automatic lookup(input logic gv, input logic [3:0] gl, input logic [7:0] busy);
        @(negedge clk);
        wr_en = 1'b0;
        grant_valid = gv; grant_lvl = gl; ch_busy = busy;
        #5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // Reset state: home levels (R1).
        lookup(1'b1, 4'd6, 8'h00); check(1, 8'h40, 1'b1);
        foreach (VECS[k]) begin
            @(negedge clk);
            wr_en = VECS[k].we; wr_ch = VECS[k].ch; wr_lvl = VECS[k].lvl;
            @(posedge clk);
            lookup(VECS[k].gv, VECS[k].gl, VECS[k].busy);
            check(int'(VECS[k].req), VECS[k].sel, VECS[k].hit);
        end
        // Directed: move ch4 to 9, then reset restores home levels (R1).
        @(negedge clk); wr_en = 1'b1; wr_ch = 3'd4; wr_lvl = 4'd9;
        @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        lookup(1'b1, 4'd4, 8'h00); check(1, 8'h10, 1'b1);
        lookup(1'b1, 4'd9, 8'h00); check(1, 8'h00, 1'b0);
        // Directed: grant valid low with a matching level (R5).
        lookup(1'b0, 4'd4, 8'h00); check(5, 8'h00, 1'b0);
        // Directed: only matching fixed channel busy, no hit (R8).
        lookup(1'b1, 4'd5, 8'h20); check(8, 8'h00, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule